// File: doc/BRIEF.md
# Period-Width Pulse Generator Timer

This block is an up-counting timer that produces a pulse-width-modulated waveform on one output. Software writes a period value and a width value, then raises the enable input. The counter starts at one and climbs by one each clock. When it reaches the width value the output goes high. When it reaches the period value the output goes low, the counter starts again at one, a one-cycle interrupt pulse is issued if interrupts are allowed, and a sticky expired flag is set. Every cycle therefore begins with the low phase. The low phase lasts `width` clocks and the whole cycle lasts `period` clocks.

The counter value is exposed as a read-only port. Software clears the expired flag through a clear strobe. When the enable input is dropped, the counter and output freeze at their current values. Raising the enable again restarts the waveform from one with the output low. Correct waveforms need the width to be below the period, and both values must be stable while the timer runs.

Top module: `pwm_period_timer`

## Requirements
- R1: After reset the count reads 0, and the output, the interrupt pulse and the expired flag are all 0.
- R2: In the first clock edge with the enable input high after it was low, the count is loaded with 1 and the output is driven low.
- R3: While enabled, the count increases by one each clock and goes back to 1 on the edge after it equals the period value, so one cycle spans `period` clocks.
- R4: While running, the output is low while the count is 1 to `width` and high while the count is `width+1` to `period`. It rises on the edge after a width match and falls on the edge after a period match.
- R5: The interrupt output is high for exactly the one cycle that follows a period match, and only if the interrupt-enable input was 1 in the matching cycle. With interrupt-enable 0 it stays 0.
- R6: The expired flag is set by every period match, whether or not interrupts are enabled, and stays set until cleared.
- R7: A clear strobe resets the expired flag on the next edge. If a period match happens in the same cycle as the strobe, the flag stays set instead.
- R8: While disabled, the count and output keep their values, and no interrupt pulse or new expiry occurs.
- R9: Re-enabling after a pause restarts the count at 1 with the output low, whatever the count was before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_en | input | 1 | Timer run enable (level) |
| irq_en | input | 1 | Allows the interrupt pulse |
| period_val | input | CNT_W | Period value |
| width_val | input | CNT_W | Low-phase length value |
| expired_clr | input | 1 | Clear strobe for the expired flag |
| count_val | output | CNT_W | Current counter value |
| pwm_out | output | 1 | Waveform output |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| expired | output | 1 | Sticky expired flag |

## Verification
The bench builds the timer with `CNT_W` = 6 instead of 32. At this width, every period from 2 to 12 can be swept against every width below it. Each pair is checked for two full waveform cycles, clock by clock, against an arithmetic model of the count, output level, interrupt and flag. Interrupt enable alternates between sweep points. Directed cases cover freezing on disable, restart on re-enable, and a clear strobe that lands on the cycle of an expiry.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
   // value loaded into the counter on start and on every period match
   localparam int unsigned RELOAD_VAL = 1;
   // comparator channel indices
   localparam int unsigned IDX_PER = 0;
   localparam int unsigned IDX_WID = 1;
   localparam int unsigned N_CMP   = 2;
endpackage

// File: rtl/pwm_tmr_cmp.sv
module pwm_tmr_cmp #(
   parameter int unsigned W = 32
) (
   input  logic         run,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] ref_val,
   output logic         hit
);
   assign hit = run && (cnt == ref_val);
endmodule

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         wrap,
   output logic         start,
   output logic         run,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] LOAD = W'(RELOAD_VAL);

   logic en_d;

   assign start = en && !en_d;
   assign run   = en && en_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_d <= 1'b0;
         cnt  <= '0;
      end else begin
         en_d <= en;
         if (start)
            cnt <= LOAD;
         else if (run)
            cnt <= wrap ? LOAD : cnt + 1'b1;
      end
   end

   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> cnt == LOAD);
   assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wrap) |=> cnt == LOAD);
   assert_hold_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cnt));
endmodule

// File: rtl/pwm_tmr_wave.sv
module pwm_tmr_wave (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic hit_per,
   input  logic hit_wid,
   output logic wave
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wave <= 1'b0;
      else if (start || hit_per)
         wave <= 1'b0;
      else if (hit_wid)
         wave <= 1'b1;
   end

   assert_fall_on_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_per |=> !wave);
   assert_rise_on_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wid && !hit_per && !start) |=> wave);
   assert_low_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !wave);
endmodule

// File: rtl/pwm_tmr_stat.sv
module pwm_tmr_stat (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_per,
   input  logic irq_en,
   input  logic clr,
   output logic irq,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         flag <= 1'b0;
      end else begin
         irq <= hit_per && irq_en;
         if (hit_per)
            flag <= 1'b1;
         else if (clr)
            flag <= 1'b0;
      end
   end

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_per |=> flag);
   assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit_per) |=> !flag);
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |=> !irq);
endmodule

// File: rtl/pwm_period_timer.sv
module pwm_period_timer
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_en,
   input  logic             irq_en,
   input  logic [CNT_W-1:0] period_val,
   input  logic [CNT_W-1:0] width_val,
   input  logic             expired_clr,
   output logic [CNT_W-1:0] count_val,
   output logic             pwm_out,
   output logic             irq_pulse,
   output logic             expired
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pwm_period_timer: CNT_W must be at least 2");
      end
   endgenerate

   logic             start;
   logic             run;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] refs [N_CMP];
   logic [N_CMP-1:0] hits;

   assign refs[IDX_PER] = period_val;
   assign refs[IDX_WID] = width_val;

   pwm_tmr_count #(.W(CNT_W)) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tmr_en),
      .wrap  (hits[IDX_PER]),
      .start (start),
      .run   (run),
      .cnt   (cnt)
   );

   for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
      pwm_tmr_cmp #(.W(CNT_W)) u_cmp (
         .run     (run),
         .cnt     (cnt),
         .ref_val (refs[i]),
         .hit     (hits[i])
      );
   end

   pwm_tmr_wave u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .hit_per (hits[IDX_PER]),
      .hit_wid (hits[IDX_WID]),
      .wave    (pwm_out)
   );

   pwm_tmr_stat u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_per (hits[IDX_PER]),
      .irq_en  (irq_en),
      .clr     (expired_clr),
      .irq     (irq_pulse),
      .flag    (expired)
   );

   assign count_val = cnt;

   assert_no_activity_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_en |=> (!irq_pulse && $stable(pwm_out)));
endmodule

// File: tb/sim_pwm_period_timer.sv
module sim_pwm_period_timer;
   localparam int unsigned W = 6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tmr_en = 1'b0;
   logic         irq_en = 1'b0;
   logic [W-1:0] period_val = '0;
   logic [W-1:0] width_val = '0;
   logic         expired_clr = 1'b0;
   logic [W-1:0] count_val;
   logic         pwm_out;
   logic         irq_pulse;
   logic         expired;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pwm_period_timer #(.CNT_W(W)) u0 (
      .clk, .rst_n, .tmr_en, .irq_en, .period_val, .width_val,
      .expired_clr, .count_val, .pwm_out, .irq_pulse, .expired
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic clear_flag();
      expired_clr = 1'b1;
      @(negedge clk);
      expired_clr = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", 32'(count_val), 0);
      chk("R1 out", 32'(pwm_out), 0);
      chk("R1 irq", 32'(irq_pulse), 0);
      chk("R1 flag", 32'(expired), 0);

      // sweep of period and width
      for (int p = 2; p <= 12; p++) begin
         for (int w = 1; w < p; w++) begin
            tmr_en = 1'b0;
            period_val = W'(p);
            width_val = W'(w);
            irq_en = ((p + w) % 2) == 1;
            @(negedge clk);
            clear_flag();
            chk("R7 clear", 32'(expired), 0);
            tmr_en = 1'b1;
            for (int k = 0; k < 2 * p + 2; k++) begin
               @(negedge clk);
               chk("R3 count", 32'(count_val), 32'((k % p) + 1));
               chk(k == 0 ? "R2 out" : "R4 out", 32'(pwm_out), 32'(((k % p) + 1) > w));
               chk("R5 irq", 32'(irq_pulse), 32'(irq_en && k >= p && (k % p) == 0));
               chk("R6 flag", 32'(expired), 32'(k >= p));
            end
         end
      end

      // R8 disable holds
      tmr_en = 1'b0;
      period_val = W'(5);
      width_val = W'(2);
      irq_en = 1'b1;
      @(negedge clk);
      tmr_en = 1'b1;
      repeat (4) @(negedge clk);   // count shows 4, out high
      tmr_en = 1'b0;
      @(negedge clk);
      chk("R8 count", 32'(count_val), 4);
      chk("R8 out", 32'(pwm_out), 1);
      clear_flag();
      repeat (10) @(negedge clk);
      chk("R8 count held", 32'(count_val), 4);
      chk("R8 out held", 32'(pwm_out), 1);
      chk("R8 no irq", 32'(irq_pulse), 0);
      chk("R8 no expiry", 32'(expired), 0);

      // R9 re-enable restarts
      tmr_en = 1'b1;
      @(negedge clk);
      chk("R9 count", 32'(count_val), 1);
      chk("R9 out", 32'(pwm_out), 0);

      // R7 clear in same cycle as expiry: count is 1 now, reaches 5 after 4 edges
      repeat (4) @(negedge clk);
      chk("R7 at period", 32'(count_val), 5);
      expired_clr = 1'b1;
      @(negedge clk);
      expired_clr = 1'b0;
      chk("R7 set wins", 32'(expired), 1);
      chk("R5 irq pulse", 32'(irq_pulse), 1);
      @(negedge clk);
      chk("R5 single cycle", 32'(irq_pulse), 0);
      chk("R6 still set", 32'(expired), 1);
      clear_flag();
      chk("R7 clear alone", 32'(expired), 0);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule